// File: doc/BRIEF.md
# Trigger-Level Byte FIFO Pair with Sticky Interrupt Status

This block buffers bytes in both directions between a register interface and a serial byte engine. A transmit FIFO is filled by software and drained by the engine. A receive FIFO is filled by the engine and drained by software. A control word enables each FIFO and sets a trigger level for each one. A packed status word shows fill levels and full/empty flags.

Seven interrupt sources are recorded as sticky status bits. Software clears them by writing ones. An enable mask selects which bits drive the single interrupt output. The sources are:
- TX almost-empty and RX almost-full, both against the programmable trigger levels.
- Overrun and underrun on each FIFO.
- A trailing-data timeout. It hands a short receive burst to software when that burst stays below the RX trigger level for a programmable number of cycles.

Top module: `trig_fifo_irq`

## Requirements
- R1: After reset, every interrupt status bit is 0, the interrupt output is 0, and the status word reads 32'h0100_0100 (both FIFOs empty, levels 0).
- R2: Each FIFO returns bytes in the order they were pushed. The status word carries the TX level in bits 6:0 and the RX level in bits 22:16.
- R3: TX full is bit 7 and TX empty is bit 8. RX full is bit 23 and RX empty is bit 24. Full means the level equals DEPTH.
- R4: A push into a full FIFO drops the byte and leaves the level unchanged. For TX it sets status bit 3; for RX it sets status bit 5.
- R5: A pop from an empty FIFO returns 8'h00. A TX pop sets status bit 2; an RX pop sets status bit 4.
- R6: Status bit 0 (TX almost-empty) is set in every cycle where TX is enabled and the TX level is at or below the TX trigger in control bits 22:16.
- R7: Status bit 1 (RX almost-full) is set in every cycle where RX is enabled and the RX level is at or above the RX trigger in control bits 10:4.
- R8: The trailing counter restarts on every RX push and is held at zero while the RX FIFO is empty. Status bit 6 is set once the counter has reached the 4-bit trailing length while the RX level is nonzero and below the RX trigger. After a last push with length L, the bit appears after L+1 idle cycles.
- R9: Writing a one to an interrupt clear bit clears that status bit on the next edge. A set event in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when some status bit and its enable bit are both 1. An all-zero enable keeps it low.
- R11: When a FIFO is disabled (control bit 0 for RX, bit 1 for TX), its contents are flushed. Pushes to it are ignored and it raises no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: bit0 RX enable, bit1 TX enable, bits 10:4 RX trigger, bits 22:16 TX trigger |
| trail_len_i | input | 4 | Trailing length in cycles |
| irq_en_i | input | 7 | Per-source interrupt enable |
| irq_clr_i | input | 7 | Write-one-to-clear strobe for status bits |
| irq_stat_o | output | 7 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt request |
| fifo_stat_o | output | 32 | Fill levels and full/empty flags |
| tx_wr_i | input | 1 | Software push into TX FIFO |
| tx_wdata_i | input | 8 | Byte pushed into TX FIFO |
| rx_rd_i | input | 1 | Software pop from RX FIFO |
| rx_rdata_o | output | 8 | RX FIFO head byte (0 when empty) |
| eng_tx_rd_i | input | 1 | Engine pop from TX FIFO |
| eng_tx_data_o | output | 8 | TX FIFO head byte (0 when empty) |
| eng_rx_wr_i | input | 1 | Engine push into RX FIFO |
| eng_rx_wdata_i | input | 8 | Byte pushed into RX FIFO |

## Verification
The assertions check on every cycle the following properties:
- Levels never exceed DEPTH.
- An overrun push leaves the level unchanged, and an underrun pop returns zero.
- A disabled FIFO is flushed.
- Each status bit obeys set-wins-over-clear.

Other behaviours need the bench's scenarios:
- Byte ordering through each FIFO.
- Trigger comparisons at their exact thresholds.
- Timing of the trailing interrupt, including a restart caused by a mid-burst push.
- Masking of the interrupt output.

The bench exercises these with directed sequences and then with long random traffic under changing triggers and enables.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  localparam int IRQ_N      = 7;
  localparam int FIELD_W    = 7;
  localparam int IRQ_TX_AE  = 0;
  localparam int IRQ_RX_AF  = 1;
  localparam int IRQ_TX_UNF = 2;
  localparam int IRQ_TX_OVF = 3;
  localparam int IRQ_RX_UNF = 4;
  localparam int IRQ_RX_OVF = 5;
  localparam int IRQ_TRAIL  = 6;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/tlf_fifo.sv
module tlf_fifo #(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          push_i,
  input  tlf_pkg::byte_t wdata_i,
  input  logic          pop_i,
  output tlf_pkg::byte_t rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tlf_pkg::byte_t mem_q [DEPTH];
  logic [AW-1:0]  wr_q, rd_q;
  logic [LW-1:0]  level_q;
  logic           push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = en_i & push_i & ~full_o;
  assign pop_ok  = en_i & pop_i & ~empty_o;
  assign ovf_o   = en_i & push_i & full_o;
  assign unf_o   = en_i & pop_i & empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_q];
  assign level_o = level_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else if (!en_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  p_ovf_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !pop_i) |=> (level_q == $past(level_q)));
  p_unf_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (rdata_o == '0));
  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (level_q == '0));
endmodule

// File: rtl/tlf_trail.sv
module tlf_trail #(
  parameter int LW = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        push_i,
  input  logic [LW-1:0]               level_i,
  input  logic [tlf_pkg::FIELD_W-1:0] trig_i,
  input  logic [3:0]                  len_i,
  output logic                        hit_o
);
  logic [3:0] cnt_q;
  logic       idle;

  assign idle  = ~en_i | (level_i == '0) | push_i;
  assign hit_o = ~idle & (tlf_pkg::FIELD_W'(level_i) < trig_i) & (cnt_q >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (idle)            cnt_q <= '0;
    else if (cnt_q < len_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_trail_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/tlf_irq.sv
module tlf_irq #(
  parameter int N = tlf_pkg::IRQ_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[i] <= 1'b0;
      else if (set_i[i]) stat_q[i] <= 1'b1;
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end

    p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !stat_q[i]);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]);
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/trig_fifo_irq.sv
module trig_fifo_irq #(
  parameter int DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ctrl_i,
  input  logic [3:0]  trail_len_i,
  input  logic [6:0]  irq_en_i,
  input  logic [6:0]  irq_clr_i,
  output logic [6:0]  irq_stat_o,
  output logic        irq_o,
  output logic [31:0] fifo_stat_o,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_wdata_i,
  input  logic        rx_rd_i,
  output logic [7:0]  rx_rdata_o,
  input  logic        eng_tx_rd_i,
  output logic [7:0]  eng_tx_data_o,
  input  logic        eng_rx_wr_i,
  input  logic [7:0]  eng_rx_wdata_i
);
  import tlf_pkg::*;
  localparam int LW = $clog2(DEPTH + 1);

  logic               rx_en, tx_en;
  logic [FIELD_W-1:0] rx_trig, tx_trig, tx_lvl7, rx_lvl7;
  logic [LW-1:0]      tx_lvl, rx_lvl;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic               tx_ovf, tx_unf, rx_ovf, rx_unf, trail_hit;
  logic [IRQ_N-1:0]   set_vec;
  logic               unused_ctrl;

  assign rx_en       = ctrl_i[0];
  assign tx_en       = ctrl_i[1];
  assign rx_trig     = ctrl_i[10:4];
  assign tx_trig     = ctrl_i[22:16];
  assign unused_ctrl = ^{ctrl_i[31:23], ctrl_i[15:11], ctrl_i[3:2]};

  tlf_fifo #(.DEPTH(DEPTH), .LW(LW)) u_tx (
    .clk_i, .rst_ni, .en_i(tx_en),
    .push_i(tx_wr_i), .wdata_i(tx_wdata_i),
    .pop_i(eng_tx_rd_i), .rdata_o(eng_tx_data_o),
    .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty),
    .ovf_o(tx_ovf), .unf_o(tx_unf)
  );

  tlf_fifo #(.DEPTH(DEPTH), .LW(LW)) u_rx (
    .clk_i, .rst_ni, .en_i(rx_en),
    .push_i(eng_rx_wr_i), .wdata_i(eng_rx_wdata_i),
    .pop_i(rx_rd_i), .rdata_o(rx_rdata_o),
    .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty),
    .ovf_o(rx_ovf), .unf_o(rx_unf)
  );

  tlf_trail #(.LW(LW)) u_trail (
    .clk_i, .rst_ni, .en_i(rx_en), .push_i(eng_rx_wr_i),
    .level_i(rx_lvl), .trig_i(rx_trig), .len_i(trail_len_i),
    .hit_o(trail_hit)
  );

  assign tx_lvl7 = FIELD_W'(tx_lvl);
  assign rx_lvl7 = FIELD_W'(rx_lvl);

  always_comb begin
    set_vec             = '0;
    set_vec[IRQ_TX_AE]  = tx_en & (tx_lvl7 <= tx_trig);
    set_vec[IRQ_RX_AF]  = rx_en & (rx_lvl7 >= rx_trig);
    set_vec[IRQ_TX_UNF] = tx_unf;
    set_vec[IRQ_TX_OVF] = tx_ovf;
    set_vec[IRQ_RX_UNF] = rx_unf;
    set_vec[IRQ_RX_OVF] = rx_ovf;
    set_vec[IRQ_TRAIL]  = trail_hit;
  end

  tlf_irq #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(irq_clr_i), .en_i(irq_en_i),
    .stat_o(irq_stat_o), .irq_o(irq_o)
  );

  assign fifo_stat_o = {7'd0, rx_empty, rx_full, rx_lvl7,
                        7'd0, tx_empty, tx_full, tx_lvl7};

  p_trail_below_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_hit |-> (!rx_empty && !eng_rx_wr_i));
endmodule

// File: tb/trig_fifo_irq_bench.sv
module trig_fifo_irq_bench;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl = '0;
  logic [3:0]  tlen = 4'hF;
  logic [6:0]  ien = '0, iclr = '0;
  logic [6:0]  irq_stat;
  logic        irq;
  logic [31:0] fstat;
  logic        tx_wr = 0, rx_rd = 0, eng_rd = 0, eng_wr = 0;
  logic [7:0]  tx_d = 0, eng_d = 0, rx_q, eng_q;

  int n_chk = 0, n_err = 0;
  logic [7:0] tq[$], rq[$];
  logic [6:0] exp_stat = '0;
  int tcnt = 0;

  always #5 clk = ~clk;

  trig_fifo_irq #(.DEPTH(D)) u_trig_fifo_irq (
    .clk_i(clk), .rst_ni, .ctrl_i(ctrl), .trail_len_i(tlen),
    .irq_en_i(ien), .irq_clr_i(iclr), .irq_stat_o(irq_stat), .irq_o(irq),
    .fifo_stat_o(fstat), .tx_wr_i(tx_wr), .tx_wdata_i(tx_d),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_q), .eng_tx_rd_i(eng_rd),
    .eng_tx_data_o(eng_q), .eng_rx_wr_i(eng_wr), .eng_rx_wdata_i(eng_d)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word();
    int t = tq.size();
    int r = rq.size();
    return {7'd0, 1'(r == 0), 1'(r == D), 7'(r), 7'd0, 1'(t == 0), 1'(t == D), 7'(t)};
  endfunction

  function automatic logic [6:0] exp_set(input logic w, input logic rr, input logic er, input logic ew);
    logic [6:0] s;
    int t = tq.size();
    int r = rq.size();
    logic txe = ctrl[1];
    logic rxe = ctrl[0];
    s[0] = txe && (t <= int'(ctrl[22:16]));
    s[1] = rxe && (r >= int'(ctrl[10:4]));
    s[2] = txe && er && t == 0;
    s[3] = txe && w && t == D;
    s[4] = rxe && rr && r == 0;
    s[5] = rxe && ew && r == D;
    s[6] = rxe && r != 0 && !ew && r < int'(ctrl[10:4]) && tcnt >= int'(tlen);
    return s;
  endfunction

  task automatic step(input logic w, input logic [7:0] wd, input logic rr,
                      input logic er, input logic ew, input logic [7:0] ed,
                      input logic [6:0] clr);
    logic [6:0] s;
    int t0, r0;
    @(negedge clk);
    tx_wr = w; tx_d = wd; rx_rd = rr; eng_rd = er; eng_wr = ew; eng_d = ed; iclr = clr;
    #1;
    chk("R2/R5 eng_tx_data", 32'(eng_q), 32'(tq.size() != 0 ? tq[0] : 8'h00));
    chk("R2/R5 rx_rdata", 32'(rx_q), 32'(rq.size() != 0 ? rq[0] : 8'h00));
    s = exp_set(w, rr, er, ew);
    t0 = tq.size(); r0 = rq.size();
    if (!ctrl[0] || r0 == 0 || ew) tcnt = 0;
    else if (tcnt < int'(tlen)) tcnt++;
    if (!ctrl[1]) tq.delete();
    else begin
      if (er && t0 != 0) void'(tq.pop_front());
      if (w && t0 != D) tq.push_back(wd);
    end
    if (!ctrl[0]) rq.delete();
    else begin
      if (rr && r0 != 0) void'(rq.pop_front());
      if (ew && r0 != D) rq.push_back(ed);
    end
    exp_stat = (exp_stat & ~clr) | s;
    @(posedge clk);
    #2;
    tx_wr = 0; rx_rd = 0; eng_rd = 0; eng_wr = 0; iclr = '0;
    chk("R2/R3 fifo_stat", fstat, exp_word());
    chk("R9 irq_stat", 32'(irq_stat), 32'(exp_stat));
    chk("R10 irq", 32'(irq), 32'(|(exp_stat & ien)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 fifo_stat reset", fstat, 32'h0100_0100);
    chk("R1 irq_stat reset", 32'(irq_stat), 0);
    chk("R1 irq reset", 32'(irq), 0);

    ctrl = (32'd2 << 16) | (32'd4 << 4) | 32'd3;
    ien = 7'h7f;
    idle(1);
    chk("R6 almost-empty at level 0", 32'(irq_stat[0]), 1);
    chk("R7 no almost-full at level 0", 32'(irq_stat[1]), 0);

    for (int i = 0; i < D; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0);
    chk("R3 tx full flag", 32'(fstat[8:7]), 32'b01);
    step(1, 8'h55, 0, 0, 0, 0, 0);
    chk("R4 tx overrun bit", 32'(irq_stat[3]), 1);
    chk("R4 tx level kept", 32'(fstat[6:0]), D);
    step(0, 0, 0, 0, 0, 0, 7'h01);
    chk("R9 clear bit0", 32'(irq_stat[0]), 0);

    for (int i = 0; i < D; i++) step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R5 tx underrun bit", 32'(irq_stat[2]), 1);
    step(0, 0, 0, 0, 0, 0, 7'h01);
    chk("R9 set wins over clear", 32'(irq_stat[0]), 1);

    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'h30 + 8'(i), 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R7 below rx trigger", 32'(irq_stat[1]), 0);
    step(0, 0, 0, 0, 1, 8'h33, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R7 at rx trigger", 32'(irq_stat[1]), 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R5 rx underrun bit", 32'(irq_stat[4]), 1);
    for (int i = 0; i < D; i++) step(0, 0, 0, 0, 1, 8'(i * 7), 0);
    chk("R3 rx full flag", 32'(fstat[24:23]), 32'b01);
    step(0, 0, 0, 0, 1, 8'hEE, 0);
    chk("R4 rx overrun bit", 32'(irq_stat[5]), 1);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);

    tlen = 4'd3;
    step(0, 0, 0, 0, 0, 0, 7'h40);
    chk("R9 clear trailing", 32'(irq_stat[6]), 0);
    step(0, 0, 0, 0, 1, 8'h71, 0);
    idle(3);
    chk("R8 trailing not yet", 32'(irq_stat[6]), 0);
    idle(1);
    chk("R8 trailing fires", 32'(irq_stat[6]), 1);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 7'h40);
    step(0, 0, 0, 0, 1, 8'h72, 0);
    idle(2);
    step(0, 0, 0, 0, 1, 8'h73, 0);
    idle(3);
    chk("R8 restart on push", 32'(irq_stat[6]), 0);
    idle(1);
    chk("R8 fires after restart", 32'(irq_stat[6]), 1);

    ien = '0;
    #1 chk("R10 masked", 32'(irq), 0);
    ien = 7'h08;
    #1 chk("R10 single enable", 32'(irq), 1);
    ien = 7'h7f;

    ctrl[1] = 1'b0;
    step(1, 8'h11, 0, 0, 0, 0, 0);
    chk("R11 tx disabled ignores push", 32'(fstat[6:0]), 0);
    ctrl[0] = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R11 rx disabled flushed", 32'(fstat[22:16]), 0);

    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0) begin
        ctrl = '0;
        ctrl[22:16] = 7'($urandom % (D + 2));
        ctrl[10:4]  = 7'($urandom % (D + 2));
        ctrl[1]     = ($urandom % 8) != 0;
        ctrl[0]     = ($urandom % 8) != 0;
        tlen        = 4'($urandom);
        ien         = 7'($urandom);
      end
      step(1'($urandom), 8'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
           1'($urandom), 8'($urandom), ($urandom % 4 == 0) ? 7'($urandom) : 7'd0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule